// File: doc/BRIEF.md
# Conditional trap comparator

This block decides whether a trap-word instruction fires. It takes two operands and a five-bit condition mask. Each mask bit enables one relation between the first operand (A) and the second (B). If any enabled relation holds, the block raises a program-trap request with a fixed cause code. An input picks between a full-width compare and a narrow compare. In the narrow compare only the low 32 bits of each operand take part, and they are read as signed or unsigned as each relation needs.

The block is driven by an evaluate strobe. A small sequencer has three states:

- **IDLE**: no evaluation is in progress.
- **HIT**: the previous evaluation trapped.
- **MISS**: the previous evaluation did not trap.

From any state the transitions are the same:

- **strobe-and-match** leads to HIT.
- **strobe-no-match** leads to MISS.
- **no-strobe** leads to IDLE.

The trap request and cause are decoded from the state register. They are therefore valid in the cycle after the strobe and last exactly one cycle unless another strobe follows. Instruction decode and the delivery of the exception lie outside the block.

Top module: `trap_cmp_unit`

## Requirements
- R1: While reset is asserted and right after it, `trap_o` is 0 and `cause_o` is 0.
- R2: Condition bit 4 (value 0x10) traps when A is less than B as signed numbers.
- R3: Condition bit 3 (value 0x08) traps when A is greater than B as signed numbers.
- R4: Condition bit 2 (value 0x04) traps when A equals B.
- R5: Condition bit 1 (value 0x02) traps when A is less than B as unsigned numbers. Condition bit 0 (value 0x01) traps when A is greater than B as unsigned numbers.
- R6: With `wide_i` = 0, only bits 31:0 of each operand are compared, and bit 31 is the sign bit. The upper bits have no effect. With `wide_i` = 1, all 64 bits are compared.
- R7: Several condition bits may be set together. The block traps when at least one selected relation holds.
- R8: A condition of 0x00 never traps. A condition of 0x1F always traps.
- R9: `trap_o` is high in the cycle after a cycle in which `eval_i` was sampled high with a matching relation. It is never high in the cycle after a cycle without `eval_i`, so a single strobe gives a single-cycle pulse.
- R10: `cause_o` is 2 (the program-trap code) whenever `trap_o` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe, sampled at the rising edge |
| wide_i | input | 1 | 1: full 64-bit compare; 0: compare the low 32 bits |
| cond_i | input | 5 | Relation-enable mask (bit4 signed lt, bit3 signed gt, bit2 eq, bit1 unsigned lt, bit0 unsigned gt) |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand |
| trap_o | output | 1 | Trap request, one cycle after the strobe |
| cause_o | output | 4 | Cause code: 2 on a trap, 0 otherwise |

## Verification
The operands are chosen so that the signed and unsigned orderings disagree, for example all-ones against one. This separates the signed condition bits from the unsigned ones. Pairs whose high halves differ but whose low halves match or swap sign show whether the narrow mode really drops the upper bits. Masks of zero, all ones and mixed single bits, together with strobe gaps and back-to-back strobes, expose errors in the OR-combination and in the timing of the one-cycle pulse. A run of pseudo-random operands and masks then compares every cycle against a behavioural model.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int COND_W  = 5;
    localparam int CAUSE_W = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 4'h0,
        CAUSE_TRAP = 4'h2
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } state_e;

    // packed field order matches condition bit positions 4..0
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

endpackage

// File: rtl/trap_rel.sv
module trap_rel
    import trap_cmp_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  logic            wide_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output rel_t            rel_o
);
    localparam int PAD = XLEN - NARROW;

    logic signed [XLEN-1:0] sa, sb;
    logic        [XLEN-1:0] ua, ub;

    generate
        if (PAD > 0) begin : g_dual
            always_comb begin
                if (wide_i) begin
                    sa = a_i;
                    sb = b_i;
                    ua = a_i;
                    ub = b_i;
                end else begin
                    sa = {{PAD{a_i[NARROW-1]}}, a_i[NARROW-1:0]};
                    sb = {{PAD{b_i[NARROW-1]}}, b_i[NARROW-1:0]};
                    ua = {{PAD{1'b0}}, a_i[NARROW-1:0]};
                    ub = {{PAD{1'b0}}, b_i[NARROW-1:0]};
                end
            end
        end else begin : g_single
            logic unused_wide;
            assign unused_wide = wide_i;
            always_comb begin
                sa = a_i;
                sb = b_i;
                ua = a_i;
                ub = b_i;
            end
        end
    endgenerate

    always_comb begin
        rel_o.slt = (sa < sb);
        rel_o.sgt = (sa > sb);
        rel_o.eq  = (ua == ub);
        rel_o.ult = (ua < ub);
        rel_o.ugt = (ua > ub);
    end

endmodule

// File: rtl/trap_pick.sv
module trap_pick
    import trap_cmp_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  rel_t              rel_i,
    output logic              hit_o
);
    logic [COND_W-1:0] sel;

    generate
        for (genvar k = 0; k < COND_W; k++) begin : g_and
            assign sel[k] = cond_i[k] & rel_i[k];
        end
    endgenerate

    assign hit_o = |sel;

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
    import trap_cmp_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eval_i,
    input  logic               wide_i,
    input  logic [COND_W-1:0]  cond_i,
    input  logic [XLEN-1:0]    src_a_i,
    input  logic [XLEN-1:0]    src_b_i,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o
);
    rel_t   rel;
    logic   hit;
    state_e state_q, state_d;

    trap_rel #(.XLEN(XLEN), .NARROW(NARROW)) u_rel (
        .wide_i (wide_i),
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .rel_o  (rel)
    );

    trap_pick u_pick (
        .cond_i (cond_i),
        .rel_i  (rel),
        .hit_o  (hit)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (eval_i) state_d = hit ? ST_HIT : ST_MISS;
                else        state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        trap_o  = (state_q == ST_HIT);
        cause_o = trap_o ? CAUSE_TRAP : CAUSE_NONE;
    end

    // R8: empty mask never traps
    a_r8_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cond_i == '0) |=> !trap_o);
    // R8: full mask always traps
    a_r8_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cond_i == '1) |=> trap_o);
    // R9: no strobe, no trap next cycle
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !trap_o);
    // R10: cause code tracks the trap request
    a_r10_cause_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> cause_o == CAUSE_TRAP);
    a_r10_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> cause_o == CAUSE_NONE);
    // R4: equal operands with the equality bit trap
    a_r4_equal_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cond_i[2] && wide_i && src_a_i == src_b_i) |=> trap_o);
    // R6: narrow equality ignores upper bits
    a_r6_narrow_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cond_i[2] && !wide_i &&
         src_a_i[NARROW-1:0] == src_b_i[NARROW-1:0]) |=> trap_o);
    // R2/R3/R4: exactly one signed ordering holds
    a_r2_signed_one: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel.slt, rel.sgt, rel.eq}) == 1);
    // R5: exactly one unsigned ordering holds
    a_r5_unsigned_one: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel.ult, rel.ugt, rel.eq}) == 1);

endmodule

// File: tb/tb_trap_cmp_unit.sv
module tb_trap_cmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        eval_i, wide_i;
    logic [4:0]  cond_i;
    logic [63:0] src_a_i, src_b_i;
    logic        trap_o;
    logic [3:0]  cause_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .wide_i(wide_i),
        .cond_i(cond_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .trap_o(trap_o), .cause_o(cause_o)
    );

    function automatic bit model(bit w, logic [4:0] c, logic [63:0] a, logic [63:0] b);
        longint          sa, sb;
        longint unsigned ua, ub;
        if (w) begin
            sa = a; sb = b; ua = a; ub = b;
        end else begin
            sa = longint'($signed(a[31:0]));
            sb = longint'($signed(b[31:0]));
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end
        return (c[4] && sa < sb) || (c[3] && sa > sb) || (c[2] && ua == ub) ||
               (c[1] && ua < ub) || (c[0] && ua > ub);
    endfunction

    task automatic check(bit exp, string req);
        logic [3:0] exp_cause;
        exp_cause = exp ? 4'h2 : 4'h0;
        tests++;
        if (trap_o !== exp || cause_o !== exp_cause) begin
            fails++;
            $display("FAIL %s: trap=%b cause=%0d, expected trap=%b cause=%0d",
                     req, trap_o, cause_o, exp, exp_cause);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic step(bit ev, bit w, logic [4:0] c, logic [63:0] a, logic [63:0] b, string req);
        bit exp;
        eval_i = ev; wide_i = w; cond_i = c; src_a_i = a; src_b_i = b;
        exp = ev ? model(w, c, a, b) : 1'b0;
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; eval_i = 1'b0; wide_i = 1'b1; cond_i = 5'h1F;
        src_a_i = '0; src_b_i = '0;
        repeat (2) @(negedge clk);
        check(1'b0, "R1 in reset");
        eval_i = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 strobe held in reset");
        eval_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 after reset");

        // all-ones vs one: signed less, unsigned greater
        step(1, 1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R2 signed lt");
        step(1, 1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R5 unsigned lt not held");
        step(1, 1, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R5 unsigned gt");
        step(1, 1, 5'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3 signed gt not held");
        step(1, 1, 5'h08, 64'h7, 64'h8000_0000_0000_0000, "R3 signed gt");
        step(1, 1, 5'h02, 64'h7, 64'h8000_0000_0000_0000, "R5 unsigned lt");
        step(1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R4 equal");
        step(1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, "R4 unequal");
        // narrow mode
        step(1, 0, 5'h04, 64'hFFFF_0000_0000_0005, 64'h5, "R6 narrow ignores upper eq");
        step(1, 1, 5'h04, 64'hFFFF_0000_0000_0005, 64'h5, "R6 wide sees upper");
        step(1, 0, 5'h10, 64'h0000_0000_8000_0000, 64'h0, "R6 narrow sign bit 31");
        step(1, 1, 5'h10, 64'h0000_0000_8000_0000, 64'h0, "R6 wide positive");
        step(1, 0, 5'h01, 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0000, "R6 narrow unsigned gt");
        // combinations
        step(1, 1, 5'h0C, 64'h5, 64'h9, "R7 gt|eq not held");
        step(1, 1, 5'h1C, 64'h5, 64'h9, "R7 lt|gt|eq held");
        step(1, 1, 5'h03, 64'h9, 64'h9, "R7 ult|ugt on equal");
        // mask extremes
        step(1, 1, 5'h00, 64'h5, 64'h9, "R8 zero mask");
        step(1, 0, 5'h00, 64'h9, 64'h9, "R8 zero mask equal");
        step(1, 1, 5'h1F, 64'h9, 64'h9, "R8 full mask");
        step(1, 0, 5'h1F, 64'h1, 64'hFFFF_FFFF, "R8 full mask narrow");
        // strobe timing
        step(0, 1, 5'h1F, 64'h1, 64'h1, "R9 no strobe");
        step(1, 1, 5'h04, 64'h3, 64'h3, "R9 strobe pulse");
        step(0, 1, 5'h04, 64'h3, 64'h3, "R9 pulse ends");
        step(1, 1, 5'h1F, 64'h3, 64'h4, "R9 back-to-back 1");
        step(1, 1, 5'h1F, 64'h4, 64'h3, "R9 back-to-back 2");
        step(1, 1, 5'h00, 64'h4, 64'h3, "R10 cause cleared");

        for (int i = 0; i < 400; i++) begin
            step(1'($urandom), 1'($urandom), 5'($urandom),
                 {$urandom, $urandom} & {{32{1'($urandom)}}, 32'hFFFF_FFFF},
                 {$urandom, $urandom} & {{32{1'($urandom)}}, 32'hFFFF_FFFF},
                 "R7 random model");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule